// File: doc/BRIEF.md
# Byte Rotate and Shift Unit with Condition Flags

This unit performs the single-position rotate, shift and nibble-exchange operations of an 8-bit accumulator-style processor. A sequencer hands it one operand byte, the current carry flag, a 3-bit operation code and a form bit. The form bit says whether the instruction is the compact one-byte accumulator variant or the two-byte escaped variant. The operand may have come from a register or from memory. The unit does not care which: the flag rules are the same in both cases.

One cycle after a valid strobe, the unit returns the new byte and the zero, subtract, half-carry and carry flags. It also returns the instruction length, so that the sequencer can advance the program counter. The result holds until the next strobe. A synchronous reset clears the result and every flag.

Top module: `shift_rot_unit`

## Requirements
- R1: Operation code 0 (circular left) moves every bit up one place and wraps the old bit 7 into bit 0; carry out equals the old bit 7 (0x80 gives 0x01 with C=1, 0x02 gives 0x04 with C=0).
- R2: Operation code 1 (circular right) moves every bit down one place and wraps the old bit 0 into bit 7; carry out equals the old bit 0 (0x01 gives 0x80 with C=1, 0x40 gives 0x20 with C=0).
- R3: Codes 2 and 3 rotate through carry. Code 2 shifts left with the incoming carry entering bit 0 and the old bit 7 leaving into C. Code 3 shifts right with the incoming carry entering bit 7 and the old bit 0 leaving into C.
- R4: Code 4 shifts left, fills bit 0 with 0 and puts the old bit 7 into C (0x01 gives 0x02 with C=0).
- R5: Code 5 shifts right, keeps bit 7 at its old value and puts the old bit 0 into C (0x01 gives 0x00 with Z=1 and C=1).
- R6: Code 7 shifts right, fills bit 7 with 0 and puts the old bit 0 into C.
- R7: Code 6 exchanges the upper and lower nibbles and always clears C.
- R8: In the escaped form (form bit 0), Z is 1 exactly when the result byte is zero. N and H are 0 for every operation in every form.
- R9: In the compact form (form bit 1 with codes 0 to 3), Z is forced to 0 even when the result is zero, and the length output is 1. The escaped form reports length 2.
- R10: The form bit has no effect with codes 4 to 7: the operation behaves as its escaped form, with Z taken from the result and length 2.
- R11: A strobe on `in_vld` produces `out_vld` and the matching results exactly one clock later. Strobes may come in back-to-back cycles. Without a strobe, `out_vld` is 0 and the result and flag outputs keep their last values.
- R12: When the synchronous reset is high at a clock edge, `out_vld`, the result, the flags and the length clear to 0, even if a strobe arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operand strobe |
| in_short | input | 1 | 1 selects the compact accumulator form |
| in_op | input | 3 | Operation code: 0 circular left, 1 circular right, 2 left through carry, 3 right through carry, 4 arithmetic left, 5 arithmetic right, 6 nibble exchange, 7 logical right |
| in_data | input | DATA_W | Operand byte |
| in_carry | input | 1 | Incoming carry flag |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| out_data | output | DATA_W | Result byte |
| out_z | output | 1 | Zero flag |
| out_n | output | 1 | Subtract flag (always 0) |
| out_h | output | 1 | Half-carry flag (always 0) |
| out_c | output | 1 | Carry flag |
| out_len | output | 2 | Instruction length in bytes (1 or 2) |

## Verification
Two things can meet in the same operation: a zero result and the compact-form rule that forces Z to 0. The bench provokes this by rotating 0x00 in the compact form, and again by rotating 0x80 left through a clear carry. It then repeats both with the form bit cleared, and expects Z=0 in the compact form and Z=1 in the escaped form.

Reset and a strobe can also fall in the same cycle. The bench raises both together and expects nothing valid and all-zero outputs one edge later.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

   typedef enum logic [2:0] {
      OP_CIRC_L  = 3'd0,
      OP_CIRC_R  = 3'd1,
      OP_THRU_L  = 3'd2,
      OP_THRU_R  = 3'd3,
      OP_ARITH_L = 3'd4,
      OP_ARITH_R = 3'd5,
      OP_NIBX    = 3'd6,
      OP_LOGIC_R = 3'd7
   } shrot_op_e;

   localparam int LEN_W     = 2;
   localparam int LEN_SHORT = 1;
   localparam int LEN_LONG  = 2;

endpackage

// File: rtl/shrot_shifter.sv
module shrot_shifter #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0]   opnd,
   input  logic                cin,
   input  shrot_pkg::shrot_op_e op,
   output logic [DATA_W-1:0]   res,
   output logic                cout
);
   localparam int MSB  = DATA_W - 1;
   localparam int HALF = DATA_W / 2;

   logic [DATA_W-1:0] swapped;

   // nibble (half-word) exchange built by index mapping
   for (genvar i = 0; i < DATA_W; i++) begin : g_swap
      assign swapped[i] = opnd[(i + HALF) % DATA_W];
   end

   always_comb begin
      res  = opnd;
      cout = 1'b0;
      unique case (op)
         shrot_pkg::OP_CIRC_L: begin
            res  = {opnd[MSB-1:0], opnd[MSB]};
            cout = opnd[MSB];
         end
         shrot_pkg::OP_CIRC_R: begin
            res  = {opnd[0], opnd[MSB:1]};
            cout = opnd[0];
         end
         shrot_pkg::OP_THRU_L: begin
            res  = {opnd[MSB-1:0], cin};
            cout = opnd[MSB];
         end
         shrot_pkg::OP_THRU_R: begin
            res  = {cin, opnd[MSB:1]};
            cout = opnd[0];
         end
         shrot_pkg::OP_ARITH_L: begin
            res  = {opnd[MSB-1:0], 1'b0};
            cout = opnd[MSB];
         end
         shrot_pkg::OP_ARITH_R: begin
            res  = {opnd[MSB], opnd[MSB:1]};
            cout = opnd[0];
         end
         shrot_pkg::OP_NIBX: begin
            res  = swapped;
            cout = 1'b0;
         end
         shrot_pkg::OP_LOGIC_R: begin
            res  = {1'b0, opnd[MSB:1]};
            cout = opnd[0];
         end
         default: begin
            res  = opnd;
            cout = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/shrot_flagger.sv
module shrot_flagger #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0]              res,
   input  logic                           short_req,
   input  shrot_pkg::shrot_op_e           op,
   output logic                           z,
   output logic [shrot_pkg::LEN_W-1:0]    len
);
   logic short_eff;

   // the compact form only exists for the four rotates (op[2] == 0)
   assign short_eff = short_req && !op[2];

   always_comb begin
      if (short_eff) begin
         z   = 1'b0;
         len = shrot_pkg::LEN_W'(shrot_pkg::LEN_SHORT);
      end else begin
         z   = (res == '0);
         len = shrot_pkg::LEN_W'(shrot_pkg::LEN_LONG);
      end
   end
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic              in_short,
   input  logic [2:0]        in_op,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_carry,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_data,
   output logic              out_z,
   output logic              out_n,
   output logic              out_h,
   output logic              out_c,
   output logic [1:0]        out_len
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("shift_rot_unit: DATA_W must be even and at least 2");
   end

   shrot_pkg::shrot_op_e op_e;
   logic [DATA_W-1:0]    nx_data;
   logic                 nx_c;
   logic                 nx_z;
   logic [1:0]           nx_len;

   assign op_e = shrot_pkg::shrot_op_e'(in_op);

   shrot_shifter #(.DATA_W(DATA_W)) u_shift (
      .opnd (in_data),
      .cin  (in_carry),
      .op   (op_e),
      .res  (nx_data),
      .cout (nx_c)
   );

   shrot_flagger #(.DATA_W(DATA_W)) u_flag (
      .res       (nx_data),
      .short_req (in_short),
      .op        (op_e),
      .z         (nx_z),
      .len       (nx_len)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld  <= 1'b0;
         out_data <= '0;
         out_z    <= 1'b0;
         out_n    <= 1'b0;
         out_h    <= 1'b0;
         out_c    <= 1'b0;
         out_len  <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            out_data <= nx_data;
            out_z    <= nx_z;
            out_n    <= 1'b0;
            out_h    <= 1'b0;
            out_c    <= nx_c;
            out_len  <= nx_len;
         end
      end
   end

   // R11: a strobe is answered on the following edge, and only then
   a_r11_vld_follow: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> out_vld);
   a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> !out_vld);
   // R11: without a strobe the result holds
   a_r11_hold: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> $stable(out_data));
   // R12: reset wins over a strobe
   a_r12_rst_clear: assert property (@(posedge clk)
      rst |=> (!out_vld && out_data == '0 && !out_c && !out_z));
   // R1: circular left takes carry from the old top bit
   a_r1_circ_carry: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_op == 3'd0) |=> (out_c == $past(in_data[MSB])));
   // R9: compact rotates never raise Z and are one byte long
   a_r9_short_z: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_short && !in_op[2]) |=> (!out_z && out_len == 2'd1));
   // R8: a non-zero result never carries Z
   a_r8_nonzero_noz: assert property (@(posedge clk) disable iff (rst)
      (out_vld && out_data != '0) |-> !out_z);
   // R10: codes 4..7 are always two bytes long
   a_r10_long_len: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_op[2]) |=> (out_len == 2'd2));

endmodule

// File: tb/sim_shift_rot_unit.sv
module sim_shift_rot_unit;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_vld = 1'b0;
   logic       in_short = 1'b0;
   logic [2:0] in_op = 3'd0;
   logic [7:0] in_data = 8'd0;
   logic       in_carry = 1'b0;
   logic       out_vld;
   logic [7:0] out_data;
   logic       out_z, out_n, out_h, out_c;
   logic [1:0] out_len;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   shift_rot_unit #(.DATA_W(8)) u0 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_short(in_short),
      .in_op(in_op), .in_data(in_data), .in_carry(in_carry),
      .out_vld(out_vld), .out_data(out_data), .out_z(out_z),
      .out_n(out_n), .out_h(out_h), .out_c(out_c), .out_len(out_len)
   );

   // expected packing: {len[1:0], n, h, z, c, data[7:0]}
   logic [13:0] exp_q[$];
   string       tag_q[$];
   logic [7:0]  last_data;

   function automatic logic [13:0] model(int op, bit sh, logic [7:0] d, bit cin);
      logic [7:0] r;
      logic c, z, se;
      logic [1:0] len;
      case (op)
         0: begin r = {d[6:0], d[7]}; c = d[7]; end     // R1
         1: begin r = {d[0], d[7:1]}; c = d[0]; end     // R2
         2: begin r = {d[6:0], cin};  c = d[7]; end     // R3
         3: begin r = {cin, d[7:1]};  c = d[0]; end     // R3
         4: begin r = {d[6:0], 1'b0}; c = d[7]; end     // R4
         5: begin r = {d[7], d[7:1]}; c = d[0]; end     // R5
         6: begin r = {d[3:0], d[7:4]}; c = 1'b0; end   // R7
         default: begin r = {1'b0, d[7:1]}; c = d[0]; end // R6
      endcase
      se  = sh && (op < 4);
      z   = se ? 1'b0 : (r == 8'd0);
      len = se ? 2'd1 : 2'd2;
      return {len, 1'b0, 1'b0, z, c, r};
   endfunction

   task automatic send(int op, bit sh, logic [7:0] d, bit cin, string tag);
      @(negedge clk);
      in_vld   = 1'b1;
      in_op    = op[2:0];
      in_short = sh;
      in_data  = d;
      in_carry = cin;
      exp_q.push_back(model(op, sh, d, cin));
      tag_q.push_back(tag);
   endtask

   task automatic idle();
      @(negedge clk);
      in_vld = 1'b0;
   endtask

   task automatic check(string tag, logic [13:0] act, logic [13:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!rst && out_vld) begin
         logic [13:0] act;
         act = {out_len, out_n, out_h, out_z, out_c, out_data};
         if (exp_q.size() == 0) begin
            check("R11 unexpected result", act, 14'h3fff);
         end else begin
            check(tag_q.pop_front(), act, exp_q.pop_front());
         end
         last_data = out_data;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R12 reset state", {out_vld, out_len, out_n, out_h, out_z, out_c, out_data[6:0]},
            14'd0);
      rst = 1'b0;

      send(0, 1, 8'h80, 0, "R1 compact circ-left 0x80");
      send(0, 0, 8'h02, 0, "R1 circ-left 0x02");
      send(1, 1, 8'h01, 0, "R2 compact circ-right 0x01");
      send(1, 0, 8'h40, 1, "R2 circ-right 0x40");
      send(2, 0, 8'h80, 0, "R3 thru-left zero escaped");
      send(2, 1, 8'h80, 0, "R9 thru-left zero compact Z forced 0");
      send(3, 0, 8'h01, 1, "R3 thru-right cin into bit7");
      send(4, 0, 8'h01, 1, "R4 arith-left 0x01");
      send(4, 0, 8'h80, 0, "R4 arith-left to zero");
      send(5, 0, 8'h01, 0, "R5 arith-right to zero");
      send(5, 0, 8'h81, 0, "R5 arith-right keeps sign");
      send(7, 0, 8'h81, 0, "R6 logic-right 0x81");
      send(6, 0, 8'hA5, 1, "R7 nibble exchange clears C");
      send(6, 0, 8'h00, 1, "R7 nibble exchange zero");
      send(0, 1, 8'h00, 0, "R9 compact zero result Z forced 0");
      send(0, 0, 8'h00, 0, "R8 escaped zero result Z=1");
      send(5, 1, 8'h01, 0, "R10 form bit ignored for arith-right");
      send(6, 1, 8'h00, 0, "R10 form bit ignored for exchange");

      // back-to-back sweep over every code, both forms, both carries
      for (int k = 0; k < 64; k++) begin
         logic [7:0] v;
         v = 8'(k * 37 + 11);
         if (k % 9 == 0) v = 8'h00;
         send(k % 8, (k / 8) % 2 == 1, v, (k / 16) % 2 == 1, "R8 R11 sweep");
      end

      idle();
      @(negedge clk);
      check("R11 idle keeps result", {5'd0, out_vld, out_data},
            {5'd0, 1'b0, last_data});

      // reset and strobe in the same cycle
      @(negedge clk);
      rst = 1'b1; in_vld = 1'b1; in_op = 3'd6; in_data = 8'hFF;
      @(negedge clk);
      check("R12 reset beats strobe",
            {out_vld, out_len, out_n, out_h, out_z, out_c, out_data[6:0]}, 14'd0);
      rst = 1'b0; in_vld = 1'b0;
      send(1, 0, 8'h03, 0, "R2 after reset");
      idle();
      repeat (3) @(negedge clk);
      check("R11 scoreboard drained", 14'(exp_q.size()), 14'd0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule